// File: doc/BRIEF.md
# Bridge Frame Verdict Unit

This block sits beside the receive path of a ring-network bridge and decides, for every received frame, which of three things the bridge does with it: copy the frame directly to the host side, flush it, or forward it across the bridge. The frame parser presents one strobe per frame together with the frame class, a flag saying whether a routing information field (RIF) is present, three address-type flags for the destination address, and the result of the address-table lookup. A static set of policy inputs controls how each frame class is treated and whether address filtering is negative (forward unknown destinations) or positive (forward known destinations only).

The decision runs in two stages. A policy stage sorts the frame into copy, flush or "filter against the table". A filter stage resolves "filter" into forward or flush using the filtering polarity, the per-address-type discard controls and the lookup hit. A small state machine registers the result and presents it as a one-cycle pulse. Its states are `ST_IDLE` (no verdict on the outputs) and `ST_ISSUE` (one verdict pulse on the outputs). The transitions are IDLE→ISSUE on a strobe, ISSUE→ISSUE on a strobe in the next cycle (back-to-back frames), ISSUE→IDLE with no strobe, and IDLE→IDLE with no strobe.

Top module: `bfv_top`

## Requirements
- R1: One clock edge after the edge that samples `frame_valid` high, exactly one of `copy_o`, `flush_o`, `fwd_o` is high for one cycle. In a cycle that does not follow a strobe, all three are low. Strobes in consecutive cycles give consecutive verdicts.
- R2: After reset, and while `rst_n` is low, all three verdict outputs are low.
- R3: A frame is "in filter scope" when it has no RIF or `tbo_en` is high. An in-scope frame of class 2'b10 (implementer-reserved) is flushed when `rsvi_en` is low.
- R4: An in-scope implementer-reserved frame with `rsvi_en` high and `rsvi_filt` low is copied.
- R5: An in-scope implementer-reserved frame with `rsvi_en` and `rsvi_filt` both high is filtered (R9 to R12).
- R6: An in-scope frame of class 2'b11 (future-reserved) follows the R3 to R5 rules with `rsvf_en` and `rsvf_filt`, independently of the implementer-reserved bits.
- R7: A frame with an RIF is copied when `tbo_en` is low, whatever its class. When `tbo_en` is high the same frame follows the in-scope rules.
- R8: An in-scope frame of class 2'b00 (MAC) or 2'b01 (LLC) is always filtered.
- R9: Under negative filtering (`pos_mode` low), a filtered frame that is not discarded by R10 is forwarded on a lookup miss and flushed on a lookup hit.
- R10: Under negative filtering, a filtered frame is flushed when its address type is broadcast and `drop_bcast` is set, functional and `drop_func` is set, or group and `drop_group` is set.
- R11: Under positive filtering (`pos_mode` high), a filtered frame is forwarded exactly when `lookup_hit` is high. `drop_bcast`, `drop_func` and `drop_group` have no effect.
- R12: The address type is decided with broadcast first, then functional, then group, then individual. A frame flagged both broadcast and group is treated only as broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: frame descriptor valid |
| frame_class | input | 2 | 00 MAC, 01 LLC, 10 implementer-reserved, 11 future-reserved |
| has_rif | input | 1 | Frame carries a routing information field |
| da_bcast | input | 1 | Destination is the all-ones broadcast address |
| da_func | input | 1 | Destination is a functional address |
| da_group | input | 1 | Destination is a group address |
| lookup_hit | input | 1 | Destination found in the address table |
| tbo_en | input | 1 | Transparent-bridging-only: apply filter rules to RIF frames too |
| pos_mode | input | 1 | 0 negative filtering, 1 positive filtering |
| drop_group | input | 1 | Negative mode: discard group destinations |
| drop_bcast | input | 1 | Negative mode: discard broadcast destinations |
| drop_func | input | 1 | Negative mode: discard functional destinations |
| rsvi_en | input | 1 | Implementer-reserved class enable |
| rsvi_filt | input | 1 | Implementer-reserved class: 1 filter, 0 copy |
| rsvf_en | input | 1 | Future-reserved class enable |
| rsvf_filt | input | 1 | Future-reserved class: 1 filter, 0 copy |
| copy_o | output | 1 | Verdict pulse: copy directly |
| flush_o | output | 1 | Verdict pulse: flush |
| fwd_o | output | 1 | Verdict pulse: forward |

## Verification
A corrupted state register or latched verdict shows at the ports in the cycle right after the strobe: there is no verdict pulse, two verdicts are high at once, a pulse stays high without a strobe, or the wrong verdict appears. Since the block carries no state across frames apart from the one-cycle pulse, each fault shows up on the first frame that reaches the faulty path. A random mix of classes, RIF settings, address flags, lookup results and policy settings, sometimes with back-to-back strobes, is compared frame by frame against an independent model. Directed frames cover the precedence and "ignored" corners.

// File: rtl/bfv_pkg.sv
package bfv_pkg;

    localparam int CLS_W = 2;

    typedef enum logic [1:0] {
        CLS_MAC  = 2'b00,
        CLS_LLC  = 2'b01,
        CLS_RSVI = 2'b10,
        CLS_RSVF = 2'b11
    } frame_cls_e;

    typedef enum logic [1:0] {
        DA_INDIV,
        DA_GROUP,
        DA_BCAST,
        DA_FUNC
    } da_kind_e;

    typedef enum logic [1:0] {
        ACT_COPY,
        ACT_FLUSH,
        ACT_FILTER
    } action_e;

    typedef enum logic [1:0] {
        VER_NONE,
        VER_COPY,
        VER_FLUSH,
        VER_FWD
    } verdict_e;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } fsm_state_e;

    typedef struct packed {
        logic tbo_en;
        logic pos_mode;
        logic drop_group;
        logic drop_bcast;
        logic drop_func;
        logic rsvi_en;
        logic rsvi_filt;
        logic rsvf_en;
        logic rsvf_filt;
    } policy_t;

endpackage

// File: rtl/bfv_da_classify.sv
module bfv_da_classify
    import bfv_pkg::*;
(
    input  logic     bcast_i,
    input  logic     func_i,
    input  logic     group_i,
    output da_kind_e kind_o
);

    // Priority: broadcast, functional, group, individual.
    always_comb begin
        if (bcast_i)
            kind_o = DA_BCAST;
        else if (func_i)
            kind_o = DA_FUNC;
        else if (group_i)
            kind_o = DA_GROUP;
        else
            kind_o = DA_INDIV;
    end

endmodule

// File: rtl/bfv_class_policy.sv
module bfv_class_policy
    import bfv_pkg::*;
#(
    parameter int CLS_WIDTH = CLS_W
) (
    input  logic [CLS_WIDTH-1:0] cls_i,
    input  logic                 rif_i,
    input  policy_t              pol_i,
    output action_e              act_o
);

    logic in_scope;
    logic cls_en;
    logic cls_filt;
    logic is_rsv;

    assign in_scope = !rif_i || pol_i.tbo_en;

    always_comb begin
        is_rsv   = 1'b0;
        cls_en   = 1'b1;
        cls_filt = 1'b1;
        unique case (frame_cls_e'(cls_i))
            CLS_MAC, CLS_LLC: begin
                is_rsv = 1'b0;
            end
            CLS_RSVI: begin
                is_rsv   = 1'b1;
                cls_en   = pol_i.rsvi_en;
                cls_filt = pol_i.rsvi_filt;
            end
            CLS_RSVF: begin
                is_rsv   = 1'b1;
                cls_en   = pol_i.rsvf_en;
                cls_filt = pol_i.rsvf_filt;
            end
            default: begin
                is_rsv = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (!in_scope)
            act_o = ACT_COPY;
        else if (!is_rsv)
            act_o = ACT_FILTER;
        else if (!cls_en)
            act_o = ACT_FLUSH;
        else if (!cls_filt)
            act_o = ACT_COPY;
        else
            act_o = ACT_FILTER;
    end

endmodule

// File: rtl/bfv_filter.sv
module bfv_filter
    import bfv_pkg::*;
(
    input  da_kind_e kind_i,
    input  logic     hit_i,
    input  policy_t  pol_i,
    output logic     pass_o
);

    logic discard;

    always_comb begin
        unique case (kind_i)
            DA_BCAST: discard = pol_i.drop_bcast;
            DA_FUNC:  discard = pol_i.drop_func;
            DA_GROUP: discard = pol_i.drop_group;
            DA_INDIV: discard = 1'b0;
            default:  discard = 1'b0;
        endcase
    end

    always_comb begin
        if (pol_i.pos_mode)
            pass_o = hit_i;
        else
            pass_o = !discard && !hit_i;
    end

endmodule

// File: rtl/bfv_top.sv
module bfv_top
    import bfv_pkg::*;
#(
    parameter int CLS_WIDTH = CLS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_valid,
    input  logic [CLS_WIDTH-1:0] frame_class,
    input  logic                 has_rif,
    input  logic                 da_bcast,
    input  logic                 da_func,
    input  logic                 da_group,
    input  logic                 lookup_hit,
    input  logic                 tbo_en,
    input  logic                 pos_mode,
    input  logic                 drop_group,
    input  logic                 drop_bcast,
    input  logic                 drop_func,
    input  logic                 rsvi_en,
    input  logic                 rsvi_filt,
    input  logic                 rsvf_en,
    input  logic                 rsvf_filt,
    output logic                 copy_o,
    output logic                 flush_o,
    output logic                 fwd_o
);

    policy_t    pol;
    da_kind_e   kind;
    action_e    act;
    logic       pass;
    verdict_e   verdict_d;
    verdict_e   verdict_q;
    fsm_state_e state_q;
    fsm_state_e state_d;

    assign pol = '{tbo_en:     tbo_en,
                   pos_mode:   pos_mode,
                   drop_group: drop_group,
                   drop_bcast: drop_bcast,
                   drop_func:  drop_func,
                   rsvi_en:    rsvi_en,
                   rsvi_filt:  rsvi_filt,
                   rsvf_en:    rsvf_en,
                   rsvf_filt:  rsvf_filt};

    bfv_da_classify u_da (
        .bcast_i (da_bcast),
        .func_i  (da_func),
        .group_i (da_group),
        .kind_o  (kind)
    );

    bfv_class_policy #(.CLS_WIDTH(CLS_WIDTH)) u_policy (
        .cls_i (frame_class),
        .rif_i (has_rif),
        .pol_i (pol),
        .act_o (act)
    );

    bfv_filter u_filter (
        .kind_i (kind),
        .hit_i  (lookup_hit),
        .pol_i  (pol),
        .pass_o (pass)
    );

    always_comb begin
        unique case (act)
            ACT_COPY:   verdict_d = VER_COPY;
            ACT_FLUSH:  verdict_d = VER_FLUSH;
            ACT_FILTER: verdict_d = pass ? VER_FWD : VER_FLUSH;
            default:    verdict_d = VER_FLUSH;
        endcase
    end

    // Next-state logic.
    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = frame_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = frame_valid ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and latched verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= VER_NONE;
        end else begin
            state_q   <= state_d;
            verdict_q <= frame_valid ? verdict_d : VER_NONE;
        end
    end

    // Output decode.
    always_comb begin
        copy_o  = 1'b0;
        flush_o = 1'b0;
        fwd_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ISSUE: begin
                copy_o  = (verdict_q == VER_COPY);
                flush_o = (verdict_q == VER_FLUSH);
                fwd_o   = (verdict_q == VER_FWD);
            end
            default: ;
        endcase
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> $countones({copy_o, flush_o, fwd_o}) == 1); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |=> !(copy_o || flush_o || fwd_o)); // R1
    AST_RSVI_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && frame_class == CLS_RSVI && !has_rif && !rsvi_en |=> flush_o); // R3
    AST_RSVF_OFF_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && frame_class == CLS_RSVF && !has_rif && !rsvf_en |=> flush_o); // R6
    AST_RIF_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && has_rif && !tbo_en |=> copy_o); // R7
    AST_POS_MISS_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && pos_mode && !lookup_hit |=> !fwd_o); // R11
    AST_NEG_HIT_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid && !pos_mode && lookup_hit |=> !fwd_o); // R9

endmodule

// File: tb/tb_bfv_top.sv
module tb_bfv_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 3000;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_valid = 1'b0;
    logic [1:0] frame_class = 2'b00;
    logic       has_rif = 1'b0;
    logic       da_bcast = 1'b0;
    logic       da_func = 1'b0;
    logic       da_group = 1'b0;
    logic       lookup_hit = 1'b0;
    logic       tbo_en = 1'b0;
    logic       pos_mode = 1'b0;
    logic       drop_group = 1'b0;
    logic       drop_bcast = 1'b0;
    logic       drop_func = 1'b0;
    logic       rsvi_en = 1'b0;
    logic       rsvi_filt = 1'b0;
    logic       rsvf_en = 1'b0;
    logic       rsvf_filt = 1'b0;
    logic       copy_o;
    logic       flush_o;
    logic       fwd_o;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfv_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_class (frame_class),
        .has_rif     (has_rif),
        .da_bcast    (da_bcast),
        .da_func     (da_func),
        .da_group    (da_group),
        .lookup_hit  (lookup_hit),
        .tbo_en      (tbo_en),
        .pos_mode    (pos_mode),
        .drop_group  (drop_group),
        .drop_bcast  (drop_bcast),
        .drop_func   (drop_func),
        .rsvi_en     (rsvi_en),
        .rsvi_filt   (rsvi_filt),
        .rsvf_en     (rsvf_en),
        .rsvf_filt   (rsvf_filt),
        .copy_o      (copy_o),
        .flush_o     (flush_o),
        .fwd_o       (fwd_o)
    );

    localparam logic [2:0] V_COPY  = 3'b100;
    localparam logic [2:0] V_FLUSH = 3'b010;
    localparam logic [2:0] V_FWD   = 3'b001;
    localparam logic [2:0] V_NONE  = 3'b000;

    // Independent model of the requirements; returns {copy, flush, fwd}.
    function automatic logic [2:0] model(output string tag);
        logic en;
        logic filt;
        if (has_rif && !tbo_en) begin
            tag = "R7";
            return V_COPY;
        end
        if (frame_class[1]) begin
            en   = frame_class[0] ? rsvf_en   : rsvi_en;
            filt = frame_class[0] ? rsvf_filt : rsvi_filt;
            if (!en) begin
                tag = frame_class[0] ? "R6" : "R3";
                return V_FLUSH;
            end
            if (!filt) begin
                tag = frame_class[0] ? "R6" : "R4";
                return V_COPY;
            end
            tag = frame_class[0] ? "R6" : "R5";
        end else begin
            tag = "R8";
        end
        if (pos_mode) begin
            tag = {tag, "/R11"};
            return lookup_hit ? V_FWD : V_FLUSH;
        end
        if (da_bcast) begin
            tag = {tag, da_group ? "/R12" : "/R10"};
            if (drop_bcast) return V_FLUSH;
        end else if (da_func) begin
            tag = {tag, "/R10"};
            if (drop_func) return V_FLUSH;
        end else if (da_group) begin
            tag = {tag, "/R10"};
            if (drop_group) return V_FLUSH;
        end
        tag = {tag, "/R9"};
        return lookup_hit ? V_FLUSH : V_FWD;
    endfunction

    task automatic check(input logic [2:0] exp, input string tag);
        logic [2:0] act;
        act = {copy_o, flush_o, fwd_o};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {copy,flush,fwd} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Inputs are already set (after a falling edge); one clock later, check.
    task automatic tick();
        logic [2:0] exp;
        string tag;
        if (frame_valid) begin
            exp = model(tag);
        end else begin
            exp = V_NONE;
            tag = "R1";
        end
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic set_pol(input logic tbo, input logic pos,
                           input logic dg, input logic db, input logic df,
                           input logic ie, input logic ifl,
                           input logic fe, input logic ffl);
        tbo_en = tbo; pos_mode = pos;
        drop_group = dg; drop_bcast = db; drop_func = df;
        rsvi_en = ie; rsvi_filt = ifl; rsvf_en = fe; rsvf_filt = ffl;
    endtask

    task automatic frame(input logic [1:0] cls, input logic rif,
                         input logic bc, input logic fn, input logic gr,
                         input logic hit);
        frame_valid = 1'b1;
        frame_class = cls; has_rif = rif;
        da_bcast = bc; da_func = fn; da_group = gr; lookup_hit = hit;
        tick();
        frame_valid = 1'b0;
        tick();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd5821));
        repeat (3) @(negedge clk);
        check(V_NONE, "R2");
        rst_n = 1'b1;
        @(negedge clk);
        check(V_NONE, "R2");
        tick();

        // R3/R4/R5: implementer-reserved, future class set opposite.
        set_pol(0, 0, 0, 0, 0, 0, 0, 1, 1);
        frame(2'b10, 0, 0, 0, 0, 0); // R3 flush
        set_pol(0, 0, 0, 0, 0, 1, 0, 0, 0);
        frame(2'b10, 0, 0, 0, 0, 0); // R4 copy
        set_pol(0, 0, 0, 0, 0, 1, 1, 0, 0);
        frame(2'b10, 0, 0, 0, 0, 0); // R5 filter, miss -> fwd
        // R6: future class uses its own pair.
        frame(2'b11, 0, 0, 0, 0, 0); // flush
        set_pol(0, 0, 0, 0, 0, 0, 0, 1, 0);
        frame(2'b11, 0, 0, 0, 0, 1); // copy
        // R7: RIF frames.
        set_pol(0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame(2'b10, 1, 0, 0, 0, 0); // copy
        set_pol(1, 0, 0, 0, 0, 0, 0, 0, 0);
        frame(2'b10, 1, 0, 0, 0, 0); // tbo: flush
        frame(2'b00, 1, 0, 0, 0, 1); // tbo MAC hit: flush
        // R8/R9: MAC and LLC filtered.
        set_pol(0, 0, 0, 0, 0, 0, 0, 0, 0);
        frame(2'b00, 0, 0, 0, 0, 0);
        frame(2'b01, 0, 0, 0, 0, 1);
        // R10: discard bits in negative mode.
        set_pol(0, 0, 1, 1, 1, 0, 0, 0, 0);
        frame(2'b01, 0, 1, 0, 0, 0);
        frame(2'b01, 0, 0, 1, 0, 0);
        frame(2'b01, 0, 0, 0, 1, 0);
        frame(2'b01, 0, 0, 0, 0, 0);
        // R11: discard bits ignored in positive mode.
        set_pol(0, 1, 1, 1, 1, 0, 0, 0, 0);
        frame(2'b00, 0, 1, 0, 0, 1);
        frame(2'b00, 0, 0, 0, 1, 1);
        frame(2'b00, 0, 0, 1, 0, 0);
        // R12: broadcast wins over group.
        set_pol(0, 0, 1, 0, 0, 0, 0, 0, 0);
        frame(2'b01, 0, 1, 0, 1, 0); // fwd
        set_pol(0, 0, 0, 1, 0, 0, 0, 0, 0);
        frame(2'b01, 0, 1, 0, 1, 0); // flush

        // Random traffic, back-to-back strobes allowed (R1).
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] r;
            r = $urandom();
            frame_valid = r[0] | r[1];
            frame_class = r[3:2];
            has_rif     = r[4];
            da_bcast    = (r[7:5] == 3'd0);
            da_func     = (r[7:5] == 3'd1) || (r[7:5] == 3'd7);
            da_group    = r[8] | (r[7:5] == 3'd0 && r[9]);
            lookup_hit  = r[10];
            if (r[31:28] == 4'd0)
                set_pol(r[11], r[12], r[13], r[14], r[15],
                        r[16], r[17], r[18], r[19]);
            tick();
        end
        frame_valid = 1'b0;
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule